// File: doc/BRIEF.md
# Audio Channel Interrupt Status

This block keeps the status word for a three-channel audio DMA engine (two playback channels, called DAC1 and DAC2, and one capture channel, called ADC). It drives a single level-sensitive interrupt line. Each channel engine sends a one-cycle pulse when its sample count runs out. The block records that pulse as a pending flag, but only while the channel's interrupt enable is on. It ORs the three pending flags into a summary bit and into the interrupt line.

A pending flag is not cleared by writing a one to it. It is cleared when software writes the serial-control word and turns the matching enable from on to off. The block keeps its own copy of the three enable bits, taken from every serial-control write.

The UART flag, the voice-interrupt flag and the three codec handshake flags come in as inputs. They appear unchanged in the status word. A two-bit source field resets to 3 and loads a new code whenever the voice-interrupt input is high.

Top module: `aud_irq_stat`

## Requirements
- R1: After reset, with all side inputs low, `status` reads 0x00000060 and `irq` is 0.
- R2: If a channel's enable is on, its completion pulse sets its pending flag at the next clock edge. The flag positions are DAC1 at status bit 2, DAC2 at bit 1 and ADC at bit 0. The pulse inputs are `done[0]` for DAC1, `done[1]` for DAC2 and `done[2]` for ADC.
- R3: A completion pulse that arrives while its channel's enable is off leaves `status` unchanged.
- R4: A serial-control write that turns an enable from 1 to 0 clears the matching pending flag at the same edge. The enable bits in `sc_wdata` are bit 8 for DAC1, bit 9 for DAC2 and bit 10 for ADC.
- R5: A serial-control write that leaves an enable at 1 does not clear that channel's pending flag.
- R6: If a disabling write and a completion pulse for the same channel happen in the same cycle, the flag ends up cleared.
- R7: Status bit 31 always equals the OR of status bits 0, 1 and 2.
- R8: `irq` equals the value status bit 31 had one clock earlier.
- R9: Status bit 3 follows `uart_pend`, bit 4 follows `ccb_pend`, and bits 8 to 10 follow `codec_flags[2:0]`, all in the same cycle. Bits 7 and 11 to 30 read 0.
- R10: Status bits 6:5 reset to 3. They load `ccb_src` at each edge where `ccb_pend` is 1, and otherwise hold their value.
- R11: An enable newly set by a write applies only from the following cycle. A completion pulse in the same cycle as the enabling write does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_we | input | 1 | Serial-control write strobe |
| sc_wdata | input | 32 | Serial-control write data |
| done | input | 3 | Sample-count-expired pulses (0 DAC1, 1 DAC2, 2 ADC) |
| uart_pend | input | 1 | UART interrupt flag, passed through |
| ccb_pend | input | 1 | Voice interrupt flag, passed through; also loads source |
| ccb_src | input | 2 | Source code loaded into status bits 6:5 |
| codec_flags | input | 3 | Codec handshake flags for bits 8 to 10 |
| status | output | 32 | Status word |
| irq | output | 1 | Registered interrupt line |

## Verification
Completion pulses are applied with the enable off, with the enable on, and in the same cycle as an enabling write. This separates the gating by the current enable from gating by the newly written value.

Serial-control writes are applied in three forms: one that keeps an enable at 1, one that turns an enable off, and one that turns an enable off in the same cycle as that channel's pulse. These cases separate an edge-triggered clear from a level-triggered clear, and show which of clear and set has priority.

A long random phase combines all inputs. A behavioural reference model checks every field on every cycle, including the one-cycle lag of `irq`.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
   localparam int unsigned NCH     = 3;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned EN_LSB  = 8;   // enable of channel c sits at EN_LSB+c
   localparam int unsigned UART_B  = 3;
   localparam int unsigned CCB_B   = 4;
   localparam int unsigned SRC_LSB = 5;
   localparam int unsigned SRC_W   = 2;
   localparam int unsigned CDC_LSB = 8;
   localparam int unsigned CDC_W   = 3;
   localparam int unsigned SUM_B   = 31;

   typedef enum logic [1:0] {CH_DAC1 = 2'd0, CH_DAC2 = 2'd1, CH_ADC = 2'd2} chan_e;

   // Status bit of channel c: playback 1 high, capture at bit 0.
   function automatic int unsigned pend_bit(input int unsigned c);
      return NCH - 1 - c;
   endfunction
endpackage

// File: rtl/aud_irq_chan.sv
module aud_irq_chan #(
   parameter int unsigned EN_POS = 8,
   parameter int unsigned W      = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         evt,
   output logic         pend
);
   logic en_q;
   logic en_nx;
   logic drop;
   logic raise;

   initial begin
      if (EN_POS >= W) $error("enable position outside word");
   end

   assign en_nx = wdata[EN_POS];
   assign drop  = wr & en_q & ~en_nx;
   assign raise = evt & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (wr) en_q <= en_nx;
         if (drop)       pend <= 1'b0;
         else if (raise) pend <= 1'b1;
      end
   end
endmodule

// File: rtl/aud_irq_line.sv
module aud_irq_line #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any,
   output logic line
);
   generate
      if (REGISTERED) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= any;
         end
         assign line = q;
      end else begin : g_comb
         assign line = any;
      end
   endgenerate
endmodule

// File: rtl/aud_irq_stat.sv
module aud_irq_stat
   import aud_irq_pkg::*;
#(
   parameter int unsigned NUM_CH  = NCH,
   parameter int unsigned DW      = WORD_W,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sc_we,
   input  logic [DW-1:0] sc_wdata,
   input  logic [NUM_CH-1:0] done,
   input  logic          uart_pend,
   input  logic          ccb_pend,
   input  logic [SRC_W-1:0] ccb_src,
   input  logic [CDC_W-1:0] codec_flags,
   output logic [DW-1:0] status,
   output logic          irq
);
   localparam logic [SRC_W-1:0] SRC_RST = '1;

   generate
      if (NUM_CH != NCH) begin : g_bad_ch
         $error("channel count must be 3");
      end
      if (DW <= SUM_B) begin : g_bad_w
         $error("status word too narrow");
      end
   endgenerate

   logic [NUM_CH-1:0] pend;
   logic [SRC_W-1:0]  src_q;
   logic              any_pend;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      aud_irq_chan #(.EN_POS(EN_LSB + c), .W(DW)) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .wr   (sc_we),
         .wdata(sc_wdata),
         .evt  (done[c]),
         .pend (pend[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        src_q <= SRC_RST;
      else if (ccb_pend) src_q <= ccb_src;
   end

   assign any_pend = |pend;

   always_comb begin
      status = '0;
      for (int c = 0; c < NUM_CH; c++) status[pend_bit(c)] = pend[c];
      status[UART_B] = uart_pend;
      status[CCB_B]  = ccb_pend;
      status[SRC_LSB +: SRC_W] = src_q;
      status[CDC_LSB +: CDC_W] = codec_flags;
      status[SUM_B]  = any_pend;
   end

   aud_irq_line #(.REGISTERED(IRQ_REG)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .any  (any_pend),
      .line (irq)
   );
endmodule

// File: rtl/aud_irq_stat_chk.sv
module aud_irq_stat_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sc_we,
   input logic [31:0] sc_wdata,
   input logic [2:0]  done,
   input logic [31:0] status,
   input logic        irq
);
   logic en1;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en1 <= 1'b0;
      else if (sc_we) en1 <= sc_wdata[8];
   end

   // R7
   sum_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[31] == (|status[2:0]));
   // R8
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(status[31]));
   // R2
   dac1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done[0] && en1 && !(sc_we && !sc_wdata[8])) |=> status[2]);
   // R3
   dac1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done[0] && !en1 && !status[2]) |=> !status[2]);
   // R4
   dac1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_we && en1 && !sc_wdata[8]) |=> !status[2]);
endmodule

bind aud_irq_stat aud_irq_stat_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sc_we(sc_we), .sc_wdata(sc_wdata),
   .done(done), .status(status), .irq(irq)
);

// File: tb/tb_aud_irq_stat.sv
`timescale 1ns/1ps
module tb_aud_irq_stat;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        sc_we = 0;
   logic [31:0] sc_wdata = 0;
   logic [2:0]  done = 0;
   logic        uart_pend = 0, ccb_pend = 0;
   logic [1:0]  ccb_src = 0;
   logic [2:0]  codec_flags = 0;
   logic [31:0] status;
   logic        irq;

   int total = 0, bad = 0;

   aud_irq_stat dut (.*);

   always #10 clk = ~clk;

   // behavioural reference
   bit m_en[3], m_pend[3], m_irq;
   int m_src;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_en[i]) begin m_en[i] = 0; m_pend[i] = 0; end
         m_irq = 0; m_src = 3;
      end else begin
         m_irq = m_pend[0] | m_pend[1] | m_pend[2];
         foreach (m_en[i]) begin
            if (sc_we && m_en[i] && !sc_wdata[8+i]) m_pend[i] = 0;
            else if (done[i] && m_en[i])            m_pend[i] = 1;
            if (sc_we) m_en[i] = sc_wdata[8+i];
         end
         if (ccb_pend) m_src = ccb_src;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // cycle-by-cycle compare against the model
   always @(negedge clk) if (rst_n) begin
      chk("R2 pending", {29'd0, status[0], status[1], status[2]},
          {29'd0, m_pend[2], m_pend[1], m_pend[0]});
      chk("R7 summary", {31'd0, status[31]}, {31'd0, m_pend[0] | m_pend[1] | m_pend[2]});
      chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 passthru", {27'd0, codec_flags != status[10:8], status[4:3], status[7]},
          {27'd0, 1'b0, ccb_pend, uart_pend, 1'b0});
      chk("R10 source", {30'd0, status[6:5]}, m_src);
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask
   task automatic idle();
      sc_we = 0; done = 0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      chk("R1 reset status", status, 32'h0000_0060);
      chk("R1 reset irq", {31'd0, irq}, 0);

      done = 3'b111; tick(); idle(); @(negedge clk);
      chk("R3 disabled pulse", status, 32'h0000_0060);

      sc_we = 1; sc_wdata = 32'h700; done = 3'b111; tick(); idle(); @(negedge clk);
      chk("R11 same-cycle enable", status, 32'h0000_0060);

      done = 3'b001; tick(); idle(); @(negedge clk);
      chk("R2 DAC1 set", status, 32'h8000_0064);
      chk("R8 irq not yet", {31'd0, irq}, 0);
      @(negedge clk);
      chk("R8 irq follows", {31'd0, irq}, 1);

      done = 3'b110; tick(); idle(); @(negedge clk);
      chk("R2 DAC2 ADC set", status, 32'h8000_0067);

      sc_we = 1; sc_wdata = 32'h700; tick(); idle(); @(negedge clk);
      chk("R5 keep enable", status, 32'h8000_0067);

      sc_we = 1; sc_wdata = 32'h600; tick(); idle(); @(negedge clk);
      chk("R4 DAC1 cleared", status, 32'h8000_0063);

      sc_we = 1; sc_wdata = 32'h400; done = 3'b010; tick(); idle(); @(negedge clk);
      chk("R6 clear wins", status, 32'h8000_0061);

      sc_we = 1; sc_wdata = 32'h0; tick(); idle(); @(negedge clk);
      chk("R4 ADC cleared", status, 32'h0000_0060);
      @(negedge clk);
      chk("R8 irq drops", {31'd0, irq}, 0);

      uart_pend = 1; ccb_pend = 1; ccb_src = 2'd1; codec_flags = 3'b101;
      tick(); @(negedge clk);
      chk("R9 R10 passthru", status, 32'h0000_0538);
      uart_pend = 0; ccb_pend = 0; ccb_src = 2'd2; codec_flags = 0;
      tick(); @(negedge clk);
      chk("R10 source held", status, 32'h0000_0020);

      for (int n = 0; n < 400; n++) begin
         sc_we = ($urandom_range(0, 3) == 0);
         sc_wdata = {21'd0, 3'($urandom), 8'($urandom)};
         done = 3'($urandom);
         uart_pend = 1'($urandom); ccb_pend = ($urandom_range(0, 7) == 0);
         ccb_src = 2'($urandom); codec_flags = 3'($urandom);
         tick();
      end
      idle();
      @(negedge clk);
      finish_run();
   end
endmodule